// File: doc/BRIEF.md
# Serial Packet Crossbar Router

This block connects sixteen bit-serial input links to sixteen bit-serial output links. Every link has one data wire, an active-low frame wire and an active-low valid wire. A sender starts a packet by pulling its frame low. The first four cycles carry a destination number, least significant bit first. Five padding cycles follow, and then a payload of any length. The sender raises frame again during the last payload cycle. The router strips the address and padding and replays the payload on the chosen output. The output carries its own frame and valid, one clock behind the input.

Each output is owned by at most one input at a time. A free output goes to the lowest-numbered input that is asking for it, and an owner keeps the output until its packet ends. The active-low busy line of each input is the back-pressure signal. In the payload phase, a cycle counts only when that input's busy_n is high. While busy_n is low, the sender holds its current payload bit, valid and frame unchanged, and the router consumes nothing. busy_n depends only on registered state, so a sender can look at it in the same cycle it drives a bit. A payload must be at least two cycles long. A new packet may start on the cycle after the last bit of the previous one.

Top module: `xbar_serial_router`

## Requirements
- R1: While rst_n is low, every tx_frame_n, tx_valid_n and rx_busy_n bit is 1, every tx_data bit is 0, and every input parser is idle.
- R2: The destination is taken from the four cycles that begin with the cycle in which rx_frame_n first reads 0. The first of these cycles is bit 0 and the last is bit 3. rx_valid_n is ignored in these cycles.
- R3: The five cycles after the address are padding, and neither padding nor address ever reaches an output. For an uncontested packet whose frame first reads 0 in cycle c, the output frame falls in cycle c+10.
- R4: Output frame falls with the first forwarded payload bit and rises with the last. An uncontested payload of n cycles occupies exactly n consecutive output cycles, and the frame is high only in the last of them.
- R5: In each forwarded payload cycle, tx_valid_n and tx_data equal the rx_valid_n and rx_data of that input cycle. The output valid pattern is therefore the input valid pattern.
- R6: When several inputs ask for the same free output, the lowest-numbered one is granted. An owner is never pre-empted while its packet is in progress.
- R7: An input in its payload phase that does not own its output has rx_busy_n low. Its held cycles are not forwarded. Its whole payload arrives intact once it is granted, and it is granted the cycle after the output frees.
- R8: If rx_frame_n reads 1 during the address or padding cycles, the packet is dropped. Nothing of it appears on any output, and an output it had claimed is released.
- R9: Packets to different outputs travel at the same time, independently and without stalls.
- R10: An output with no packet in progress holds tx_frame_n and tx_valid_n at 1 and tx_data at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 16 | Serial data, one bit per input |
| rx_frame_n | input | 16 | Active-low packet frame per input |
| rx_valid_n | input | 16 | Active-low payload valid per input |
| rx_busy_n | output | 16 | Active-low back-pressure per input |
| tx_data | output | 16 | Serial data, one bit per output |
| tx_frame_n | output | 16 | Active-low packet frame per output |
| tx_valid_n | output | 16 | Active-low payload valid per output |

## Verification
The bound checker watches four things on every cycle. It checks that outputs are quiet in reset and between packets. It checks that an output frame only falls while the output has an owner, and that ownership never changes without a free cycle in between. It also checks that a busy input was requesting in the previous cycle. Address bit order, padding length, exact output latency, the valid pattern, priority order, intact delivery after a stall and dropping of aborted packets can only be shown by the bench's scenarios. Directed contention, abort and all-ports tests cover these, together with seeded random traffic whose payloads are matched by content against bench-computed expectations.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_PAD  = 2'd2,
    PH_XFER = 2'd3
  } rtr_phase_e;
endpackage

// File: rtl/rtr_in_parser.sv
module rtr_in_parser
  import rtr_pkg::*;
#(
  parameter int AW  = 4,
  parameter int PAD = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          data,
  input  logic          gnt,
  output logic          req,
  output logic          xfer,
  output logic          done,
  output logic [AW-1:0] dst
);
  localparam int MAXC = (AW > PAD) ? AW : PAD;
  localparam int CW   = $clog2(MAXC + 1);

  rtr_phase_e    phase;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      addr  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (!frame_n) begin
          addr  <= {data, addr[AW-1:1]};
          cnt   <= CW'(1);
          phase <= (AW == 1) ? PH_PAD : PH_ADDR;
          if (AW == 1) cnt <= '0;
        end
        PH_ADDR: begin
          if (frame_n) begin
            phase <= PH_IDLE;
          end else begin
            addr <= {data, addr[AW-1:1]};
            if (cnt == CW'(AW - 1)) begin
              cnt   <= '0;
              phase <= PH_PAD;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        PH_PAD: begin
          if (frame_n) begin
            phase <= PH_IDLE;
          end else if (cnt == CW'(PAD - 1)) begin
            cnt   <= '0;
            phase <= PH_XFER;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_XFER: if (gnt && frame_n) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign dst  = addr;
  assign req  = (phase == PH_PAD) || (phase == PH_XFER);
  assign xfer = (phase == PH_XFER);
  assign done = frame_n && (((phase == PH_PAD)) || ((phase == PH_XFER) && gnt));
endmodule

// File: rtl/rtr_out_port.sv
module rtr_out_port #(
  parameter int N    = 16,
  parameter int AW   = 4,
  parameter int IW   = 4,
  parameter int PORT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic [N-1:0]         done,
  input  logic [N-1:0]         xfer,
  input  logic [N-1:0][AW-1:0] dst,
  input  logic [N-1:0]         rx_data,
  input  logic [N-1:0]         rx_frame_n,
  input  logic [N-1:0]         rx_valid_n,
  output logic                 own_vld,
  output logic [IW-1:0]        own_idx,
  output logic                 tx_data,
  output logic                 tx_frame_n,
  output logic                 tx_valid_n
);
  localparam logic [AW-1:0] MY_ADDR = AW'(PORT);

  logic [N-1:0]  hit;
  logic          pick_vld;
  logic [IW-1:0] pick;
  logic          fwd;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit[i] = req[i] && !done[i] && (dst[i] == MY_ADDR);
    end
  end

  // Lowest index wins: scan downward so the last hit written is the smallest.
  always_comb begin
    pick_vld = 1'b0;
    pick     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick_vld = 1'b1;
        pick     = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (own_vld) begin
      if (done[own_idx]) own_vld <= 1'b0;
    end else if (pick_vld) begin
      own_vld <= 1'b1;
      own_idx <= pick;
    end
  end

  assign fwd = own_vld && xfer[own_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data    <= 1'b0;
      tx_frame_n <= 1'b1;
      tx_valid_n <= 1'b1;
    end else begin
      tx_data    <= fwd ? rx_data[own_idx]    : 1'b0;
      tx_frame_n <= fwd ? rx_frame_n[own_idx] : 1'b1;
      tx_valid_n <= fwd ? rx_valid_n[own_idx] : 1'b1;
    end
  end
endmodule

// File: rtl/xbar_serial_router.sv
module xbar_serial_router #(
  parameter int NPORT      = 16,
  parameter int PAD_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] rx_data,
  input  logic [NPORT-1:0] rx_frame_n,
  input  logic [NPORT-1:0] rx_valid_n,
  output logic [NPORT-1:0] rx_busy_n,
  output logic [NPORT-1:0] tx_data,
  output logic [NPORT-1:0] tx_frame_n,
  output logic [NPORT-1:0] tx_valid_n
);
  localparam int AW = $clog2(NPORT);
  localparam int IW = AW;

  logic [NPORT-1:0]         p_req;
  logic [NPORT-1:0]         p_xfer;
  logic [NPORT-1:0]         p_done;
  logic [NPORT-1:0]         p_gnt;
  logic [NPORT-1:0][AW-1:0] p_dst;
  logic [NPORT-1:0]         own_vld;
  logic [NPORT-1:0][IW-1:0] own_idx;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    rtr_in_parser #(.AW(AW), .PAD(PAD_CYCLES)) u_parse (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (rx_frame_n[i]),
      .data    (rx_data[i]),
      .gnt     (p_gnt[i]),
      .req     (p_req[i]),
      .xfer    (p_xfer[i]),
      .done    (p_done[i]),
      .dst     (p_dst[i])
    );
    assign p_gnt[i]     = own_vld[p_dst[i]] && (own_idx[p_dst[i]] == IW'(i));
    assign rx_busy_n[i] = !(p_xfer[i] && !p_gnt[i]);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    rtr_out_port #(.N(NPORT), .AW(AW), .IW(IW), .PORT(o)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (p_req),
      .done       (p_done),
      .xfer       (p_xfer),
      .dst        (p_dst),
      .rx_data    (rx_data),
      .rx_frame_n (rx_frame_n),
      .rx_valid_n (rx_valid_n),
      .own_vld    (own_vld[o]),
      .own_idx    (own_idx[o]),
      .tx_data    (tx_data[o]),
      .tx_frame_n (tx_frame_n[o]),
      .tx_valid_n (tx_valid_n[o])
    );
  end
endmodule

// File: rtl/rtr_checker.sv
module rtr_checker #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         tx_data,
  input logic [N-1:0]         tx_frame_n,
  input logic [N-1:0]         tx_valid_n,
  input logic [N-1:0]         rx_busy_n,
  input logic [N-1:0]         own_vld,
  input logic [N-1:0][IW-1:0] own_idx,
  input logic [N-1:0]         p_req
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert ((&tx_frame_n) && (&tx_valid_n) && (&rx_busy_n) && (tx_data == '0))
        else $error("reset state violated");
    end
  end

  for (genvar o = 0; o < N; o++) begin : g_o
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_frame_n[o] && $past(tx_frame_n[o])) |-> (tx_valid_n[o] && !tx_data[o]));

    assert_frame_needs_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_frame_n[o]) |-> $past(own_vld[o]));

    assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(own_vld[o]) && own_vld[o]) |-> (own_idx[o] == $past(own_idx[o])));
  end

  for (genvar i = 0; i < N; i++) begin : g_i
    assert_busy_after_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_busy_n[i] |-> $past(p_req[i]));
  end
endmodule

bind xbar_serial_router rtr_checker #(.N(NPORT), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_data    (tx_data),
  .tx_frame_n (tx_frame_n),
  .tx_valid_n (tx_valid_n),
  .rx_busy_n  (rx_busy_n),
  .own_vld    (own_vld),
  .own_idx    (own_idx),
  .p_req      (p_req)
);

// File: tb/xbar_serial_router_tb.sv
module xbar_serial_router_tb;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] rx_data = '0;
  logic [NP-1:0] rx_frame_n = '1;
  logic [NP-1:0] rx_valid_n = '1;
  logic [NP-1:0] rx_busy_n, tx_data, tx_frame_n, tx_valid_n;

  int checks = 0, errors = 0, cyc = 0, active = 0;
  bit mon_en = 1'b0, finished = 1'b0;

  logic [63:0] exp_bits [NP][$];
  int          exp_len  [NP][$];
  logic [63:0] rcv_bits [NP][$];
  int          start_cyc[NP], stalls[NP], fall_cyc[NP], rise_cyc[NP], last_ncyc[NP];
  logic [63:0] last_vpat[NP];
  bit          in_pkt[NP];
  logic [63:0] cur_bits[NP], cur_vp[NP];
  int          cur_len[NP], cur_ncyc[NP];

  xbar_serial_router u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_frame_n(rx_frame_n),
    .rx_valid_n(rx_valid_n), .rx_busy_n(rx_busy_n), .tx_data(tx_data),
    .tx_frame_n(tx_frame_n), .tx_valid_n(tx_valid_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_valid(input logic [63:0] dat, input logic [63:0] vld, input int n);
    logic [63:0] r = '0;
    int c = 0;
    for (int k = 0; k < n; k++) if (vld[k]) begin r[c] = dat[k]; c++; end
    return r;
  endfunction

  function automatic int count_valid(input logic [63:0] vld, input int n);
    int c = 0;
    for (int k = 0; k < n; k++) if (vld[k]) c++;
    return c;
  endfunction

  // Output monitor: collects valid payload bits per output packet, matches by content.
  always @(negedge clk) begin
    if (mon_en) begin
      for (int o = 0; o < NP; o++) begin
        if (in_pkt[o] || !tx_frame_n[o]) begin
          if (!in_pkt[o]) begin
            in_pkt[o] = 1'b1; fall_cyc[o] = cyc;
            cur_bits[o] = '0; cur_vp[o] = '0; cur_len[o] = 0; cur_ncyc[o] = 0;
          end
          if (!tx_valid_n[o]) begin cur_bits[o][cur_len[o]] = tx_data[o]; cur_len[o]++; end
          cur_vp[o][cur_ncyc[o]] = !tx_valid_n[o];
          cur_ncyc[o]++;
          if (tx_frame_n[o]) begin
            int hit_idx = -1;
            in_pkt[o] = 1'b0; rise_cyc[o] = cyc;
            last_vpat[o] = cur_vp[o]; last_ncyc[o] = cur_ncyc[o];
            rcv_bits[o].push_back(cur_bits[o]);
            for (int q = 0; q < exp_len[o].size(); q++)
              if (hit_idx < 0 && exp_len[o][q] == cur_len[o] && exp_bits[o][q] == cur_bits[o]) hit_idx = q;
            chk(hit_idx >= 0, "R2/R5", $sformatf("output %0d packet content", o),
                cur_bits[o], (exp_bits[o].size() > 0) ? exp_bits[o][0] : 64'h0);
            if (hit_idx >= 0) begin exp_len[o].delete(hit_idx); exp_bits[o].delete(hit_idx); end
          end
        end
      end
    end
  end

  task automatic send(input int p, input int d, input int n, input logic [63:0] dat,
                      input logic [63:0] vld, input int dly);
    active++;
    exp_bits[d].push_back(pack_valid(dat, vld, n));
    exp_len[d].push_back(count_valid(vld, n));
    repeat (dly) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      if (a == 0) start_cyc[p] = cyc;
      rx_frame_n[p] = 1'b0; rx_data[p] = d[a]; rx_valid_n[p] = 1'($urandom % 2);
    end
    for (int a = 0; a < 5; a++) begin
      @(negedge clk);
      rx_valid_n[p] = 1'b1; rx_data[p] = 1'($urandom % 2);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_data[p] = dat[k]; rx_valid_n[p] = !vld[k]; rx_frame_n[p] = (k == n - 1);
      while (!rx_busy_n[p]) begin stalls[p]++; @(negedge clk); end
    end
    @(negedge clk);
    rx_frame_n[p] = 1'b1; rx_valid_n[p] = 1'b1; rx_data[p] = 1'b0;
    active--;
  endtask

  task automatic abort_pkt(input int p, input int d, input int cut);
    for (int a = 0; a < cut; a++) begin
      @(negedge clk);
      rx_frame_n[p] = 1'b0; rx_valid_n[p] = (a < 4) ? 1'($urandom % 2) : 1'b1;
      rx_data[p] = (a < 4) ? d[a] : 1'b0;
    end
    @(negedge clk);
    rx_frame_n[p] = 1'b1; rx_valid_n[p] = 1'b1; rx_data[p] = 1'b0;
  endtask

  task automatic settle(input int n);
    wait (active == 0);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    for (int o = 0; o < NP; o++) begin rcv_bits[o].delete(); stalls[o] = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int o = 0; o < NP; o++) begin in_pkt[o] = 1'b0; stalls[o] = 0; end
    repeat (3) @(negedge clk);
    // R1 / R10: reset and idle state
    chk(tx_frame_n == '1, "R1", "tx_frame_n in reset", tx_frame_n, 16'hffff);
    chk(tx_valid_n == '1, "R1", "tx_valid_n in reset", tx_valid_n, 16'hffff);
    chk(rx_busy_n  == '1, "R1", "rx_busy_n in reset", rx_busy_n, 16'hffff);
    chk(tx_data    == '0, "R1", "tx_data in reset", tx_data, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_frame_n == '1 && tx_valid_n == '1 && tx_data == '0, "R10", "idle outputs",
        {tx_frame_n, tx_valid_n}, 32'hffffffff);

    // R3 R4 R5: one uncontested packet, latency, shape and valid pattern
    clear_log();
    send(3, 9, 6, 64'h2d, 64'h2d, 0);
    settle(4);
    chk(fall_cyc[9] == start_cyc[3] + 10, "R3", "output frame fall cycle", fall_cyc[9], start_cyc[3] + 10);
    chk(rise_cyc[9] == start_cyc[3] + 15, "R4", "output frame rise cycle", rise_cyc[9], start_cyc[3] + 15);
    chk(last_ncyc[9] == 6, "R4", "output packet cycles", last_ncyc[9], 6);
    chk(last_vpat[9][5:0] == 6'h2d, "R5", "output valid pattern", last_vpat[9][5:0], 6'h2d);
    chk(rcv_bits[9].size() == 1, "R3", "single packet on output 9", rcv_bits[9].size(), 1);

    // R6 R7: simultaneous contenders, lower index wins, loser stalls intact
    clear_log();
    fork
      send(5, 7, 8, 64'h3c, 64'hff, 0);
      send(2, 7, 8, 64'ha5, 64'hff, 0);
    join
    settle(4);
    chk(rcv_bits[7].size() == 2, "R7", "both contenders delivered", rcv_bits[7].size(), 2);
    chk(rcv_bits[7].size() > 0 && rcv_bits[7][0] == 64'ha5, "R6", "lowest index first",
        (rcv_bits[7].size() > 0) ? rcv_bits[7][0] : 64'h0, 64'ha5);
    chk(stalls[2] == 0, "R7", "winner never busy", stalls[2], 0);
    chk(stalls[5] > 0, "R7", "loser saw busy", stalls[5], 1);

    // R6: no pre-emption of an owner by a lower index
    clear_log();
    fork
      send(8, 4, 12, 64'h5a3, 64'hfff, 0);
      send(1, 4, 6, 64'h15, 64'h3f, 3);
    join
    settle(4);
    chk(rcv_bits[4].size() > 0 && rcv_bits[4][0] == 64'h5a3, "R6", "owner kept output",
        (rcv_bits[4].size() > 0) ? rcv_bits[4][0] : 64'h0, 64'h5a3);
    chk(stalls[1] > 0, "R7", "late low index stalled", stalls[1], 1);

    // R8: aborts in padding and in address phase
    clear_log();
    abort_pkt(6, 11, 6);
    abort_pkt(6, 11, 2);
    repeat (12) @(negedge clk);
    chk(rcv_bits[11].size() == 0, "R8", "aborted packets not forwarded", rcv_bits[11].size(), 0);
    send(10, 11, 5, 64'h13, 64'h1f, 0);
    settle(4);
    chk(rcv_bits[11].size() == 1, "R8", "output released after abort", rcv_bits[11].size(), 1);
    chk(stalls[10] == 0, "R8", "no stall after abort", stalls[10], 0);

    // R9: all ports to distinct outputs at once
    clear_log();
    for (int p = 0; p < NP; p++) begin
      automatic int pp = p;
      fork send(pp, (pp + 3) % NP, 10, 64'($urandom), 64'h3ff, 0); join_none
    end
    #1;
    settle(4);
    for (int p = 0; p < NP; p++) begin
      chk(fall_cyc[(p + 3) % NP] == start_cyc[p] + 10, "R9", $sformatf("port %0d concurrent latency", p),
          fall_cyc[(p + 3) % NP], start_cyc[p] + 10);
      chk(stalls[p] == 0, "R9", $sformatf("port %0d no stall", p), stalls[p], 0);
    end

    // Seeded random traffic mixing contention, valid gaps and lengths
    for (int r = 0; r < 40; r++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom % 2 == 1) begin
          automatic int pp = p;
          automatic int dd = int'($urandom % NP);
          automatic int nn = 2 + int'($urandom % 23);
          automatic logic [63:0] db = {$urandom, $urandom};
          automatic logic [63:0] vb = {$urandom, $urandom};
          automatic int dl = int'($urandom % 7);
          fork send(pp, dd, nn, db, vb, dl); join_none
        end
      end
      #1;
      settle(3);
    end
    repeat (10) @(negedge clk);
    for (int o = 0; o < NP; o++)
      chk(exp_len[o].size() == 0, "R2", $sformatf("output %0d undelivered packets", o), exp_len[o].size(), 0);
    chk(tx_frame_n == '1 && tx_valid_n == '1 && tx_data == '0 && rx_busy_n == '1, "R10",
        "quiet after traffic", {tx_frame_n, tx_valid_n}, 32'hffffffff);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule